// File: doc/BRIEF.md
# Striped Multi-Bank Video Memory Arbiter

This block sits between a raster display reader and a processor-side writer and holds the frame buffer. The frame is cut into horizontal stripes of equal height, and each stripe lives in its own RAM bank with its own address, data and enable wiring. With two banks, the first holds the top half of the picture and the second holds the bottom half.

While the display scans a line, the bank that owns that line is given to the reader. Every other bank stays open to the write port, so the display and the writer work at the same time. A state output names the bank that the reader currently owns. The writer uses it to send data for stripes that are not being shown. During vertical blanking the reader owns no bank, the state output shows a reserved code, and the writer may fill any stripe.

Top module: `stripe_vram_arbiter`

## Requirements
- R1: After reset, rd_valid is 0 and rd_data is 0.
- R2: While rd_blank is 0, rd_bank equals rd_line divided by LINES/NUM_BANKS (integer division), in the same cycle that rd_line is presented.
- R3: While rd_blank is 1, rd_bank shows the reserved code with all bits set (3 for the default of two banks), and no bank is owned by the reader.
- R4: A write whose target bank (wr_line divided by LINES/NUM_BANKS) differs from the bank owned by the reader sees wr_ready high in the same cycle and is stored at the clock edge.
- R5: A write whose target bank equals the bank owned by the reader sees wr_ready low and is not stored. It is accepted as soon as the reader moves to another bank or blanking begins.
- R6: While rd_blank is 1, wr_ready is high for every target bank.
- R7: A read presented with rd_en high and rd_blank low returns the stored pixel on rd_data, with rd_valid high, exactly one cycle later.
- R8: A read presented while rd_blank is 1 is ignored: rd_valid is 0 in the next cycle and rd_data keeps its previous value.
- R9: Each (line, column) position keeps its own value. Line l is held in bank l/(LINES/NUM_BANKS) at in-bank offset l mod (LINES/NUM_BANKS), and writes to one position leave all others unchanged.
- R10: A cycle with wr_valid low changes no stored pixel, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Display read request for this cycle |
| rd_blank | input | 1 | Vertical blanking; reader owns no bank |
| rd_line | input | $clog2(LINES) | Current scan line |
| rd_col | input | $clog2(WIDTH) | Pixel column of the read |
| rd_valid | output | 1 | rd_data carries the result of the previous cycle's read |
| rd_data | output | DATA_W | Read pixel, one cycle after the request |
| rd_bank | output | $clog2(NUM_BANKS+1) | Bank owned by the reader, or all ones during blanking |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_line | input | $clog2(LINES) | Target line of the write |
| wr_col | input | $clog2(WIDTH) | Target column of the write |
| wr_data | input | DATA_W | Pixel to store |

## Verification
The assertions assume that rd_line and wr_line stay below LINES and that the column inputs stay below WIDTH, so every bank index and in-bank address is in range. They also assume that inputs change only away from the clock edge. The stimulus comes from a bench-side frame model. It only generates line and column values inside the frame. It holds a refused write unchanged until the model predicts acceptance, and it walks the scan line across every stripe boundary with the writer aimed both at the owned bank and at the free ones.

// File: rtl/svram_pkg.sv
package svram_pkg;
   // Width of an index field; never below one bit so that degenerate
   // parameter sets still produce legal vectors.
   function automatic int idx_width(input int count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/svram_bank_ram.sv
module svram_bank_ram #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              re,
   input  logic              we,
   input  logic [ADDR_W-1:0] raddr,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] port_addr;

   // single port: one address, picked by whichever side uses the bank
   assign port_addr = re ? raddr : waddr;

   always_ff @(posedge clk) begin
      if (we) mem[port_addr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (re) q <= mem[port_addr];
   end

   AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(re && we)); // R4
   AST_Q_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(q)); // R8
endmodule

// File: rtl/svram_bank_router.sv
module svram_bank_router
   import svram_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int LINES     = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  rd_en,
   input  logic                                  rd_blank,
   input  logic [idx_width(LINES)-1:0]           rd_line,
   input  logic                                  wr_valid,
   input  logic [idx_width(LINES)-1:0]           wr_line,
   output logic [$clog2(NUM_BANKS+1)-1:0]        rd_bank,
   output logic                                  wr_ready,
   output logic [NUM_BANKS-1:0]                  bank_re,
   output logic [NUM_BANKS-1:0]                  bank_we
);
   localparam int LINE_W = idx_width(LINES);
   localparam int BIDX_W = $clog2(NUM_BANKS + 1);
   localparam int LPB    = LINES / NUM_BANKS;
   localparam logic [BIDX_W-1:0] NONE_CODE = '1;

   logic [LINE_W-1:0] rd_idx;
   logic [LINE_W-1:0] wr_idx;
   logic              wr_hit;

   // stripe index: a shift when the stripe height is a power of two,
   // a constant divide otherwise
   generate
      if (is_pow2(LPB)) begin : g_shift
         localparam int SH = $clog2(LPB);
         assign rd_idx = rd_line >> SH;
         assign wr_idx = wr_line >> SH;
      end else begin : g_divide
         assign rd_idx = rd_line / LINE_W'(LPB);
         assign wr_idx = wr_line / LINE_W'(LPB);
      end
   endgenerate

   assign rd_bank  = rd_blank ? NONE_CODE : BIDX_W'(rd_idx);
   assign wr_hit   = !rd_blank && (wr_idx == rd_idx);
   assign wr_ready = !wr_hit;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_sel
         assign bank_re[b] = rd_en && !rd_blank && (rd_idx == LINE_W'(b));
         assign bank_we[b] = wr_valid && wr_ready && (wr_idx == LINE_W'(b));
      end
   endgenerate

   AST_ONE_READ_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_re)); // R2
   AST_ONE_WRITE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we)); // R9
   AST_BLANK_WRITES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_blank |-> wr_ready); // R6
   AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_bank < BIDX_W'(NUM_BANKS)) || (rd_bank == NONE_CODE)); // R3
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |-> (bank_we == '0)); // R10
endmodule

// File: rtl/stripe_vram_arbiter.sv
module stripe_vram_arbiter
   import svram_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int LINES     = 8,
   parameter int WIDTH     = 8,
   parameter int DATA_W    = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  rd_en,
   input  logic                                  rd_blank,
   input  logic [idx_width(LINES)-1:0]           rd_line,
   input  logic [idx_width(WIDTH)-1:0]           rd_col,
   output logic                                  rd_valid,
   output logic [DATA_W-1:0]                     rd_data,
   output logic [$clog2(NUM_BANKS+1)-1:0]        rd_bank,
   input  logic                                  wr_valid,
   output logic                                  wr_ready,
   input  logic [idx_width(LINES)-1:0]           wr_line,
   input  logic [idx_width(WIDTH)-1:0]           wr_col,
   input  logic [DATA_W-1:0]                     wr_data
);
   localparam int LINE_W = idx_width(LINES);
   localparam int COL_W  = idx_width(WIDTH);
   localparam int BIDX_W = $clog2(NUM_BANKS + 1);
   localparam int LPB    = LINES / NUM_BANKS;
   localparam int OFF_W  = idx_width(LPB);
   localparam int ADDR_W = OFF_W + COL_W;

   generate
      if (NUM_BANKS < 2) begin : g_chk_banks
         $error("stripe_vram_arbiter: NUM_BANKS must be at least 2");
      end
      if (LINES % NUM_BANKS != 0) begin : g_chk_stripes
         $error("stripe_vram_arbiter: LINES must be a multiple of NUM_BANKS");
      end
      if (WIDTH < 2 || DATA_W < 1) begin : g_chk_geom
         $error("stripe_vram_arbiter: WIDTH must be at least 2 and DATA_W positive");
      end
   endgenerate

   logic [NUM_BANKS-1:0] bank_re;
   logic [NUM_BANKS-1:0] bank_we;
   logic [DATA_W-1:0]    bank_q [NUM_BANKS];
   logic [LINE_W-1:0]    rd_off_full, wr_off_full;
   logic [ADDR_W-1:0]    rd_addr, wr_addr;
   logic [BIDX_W-1:0]    sel_q;
   logic                 rvld_q;

   svram_bank_router #(
      .NUM_BANKS (NUM_BANKS),
      .LINES     (LINES)
   ) u_router (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_blank (rd_blank),
      .rd_line  (rd_line),
      .wr_valid (wr_valid),
      .wr_line  (wr_line),
      .rd_bank  (rd_bank),
      .wr_ready (wr_ready),
      .bank_re  (bank_re),
      .bank_we  (bank_we)
   );

   // in-stripe line offset placed above the pixel column
   assign rd_off_full = rd_line % LINE_W'(LPB);
   assign wr_off_full = wr_line % LINE_W'(LPB);
   assign rd_addr     = {rd_off_full[OFF_W-1:0], rd_col};
   assign wr_addr     = {wr_off_full[OFF_W-1:0], wr_col};

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         svram_bank_ram #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W)
         ) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .re    (bank_re[b]),
            .we    (bank_we[b]),
            .raddr (rd_addr),
            .waddr (wr_addr),
            .wdata (wr_data),
            .q     (bank_q[b])
         );
      end
   endgenerate

   // remember which bank answers; held while no read is issued
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= '0;
         rvld_q <= 1'b0;
      end else begin
         rvld_q <= |bank_re;
         if (|bank_re) sel_q <= rd_bank;
      end
   end

   assign rd_valid = rvld_q;
   assign rd_data  = bank_q[sel_q];

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_blank) |=> rd_valid); // R7
   AST_BLANK_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_blank |=> !rd_valid); // R8
   AST_HELD_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && !rd_blank) |=> $stable(rd_data)); // R8
   AST_OWNED_BANK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !rd_blank && (bank_we != '0)) |-> ((bank_we & bank_re) == '0)); // R5
endmodule

// File: tb/tb_stripe_vram_arbiter.sv
`timescale 1ns/1ps
module tb_stripe_vram_arbiter;
   localparam int NB = 2;
   localparam int NL = 8;
   localparam int NW = 8;
   localparam int DW = 8;
   localparam int LPB = NL / NB;
   localparam int NONE = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_en = 1'b0, rd_blank = 1'b1;
   logic [2:0] rd_line = '0, rd_col = '0;
   logic rd_valid;
   logic [DW-1:0] rd_data;
   logic [1:0] rd_bank;
   logic wr_valid = 1'b0;
   logic wr_ready;
   logic [2:0] wr_line = '0, wr_col = '0;
   logic [DW-1:0] wr_data = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int model [NL*NW];
   bit exp_rv = 1'b0;
   int exp_rd = 0;
   string rtag = "R1";

   always #2 clk = ~clk;

   stripe_vram_arbiter #(.NUM_BANKS(NB), .LINES(NL), .WIDTH(NW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_blank(rd_blank),
      .rd_line(rd_line), .rd_col(rd_col), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_bank(rd_bank), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_line(wr_line), .wr_col(wr_col), .wr_data(wr_data));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act %0d exp %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: check registered results, drive, check combinational
   // results, advance the model, step to the next falling edge
   task automatic cyc(input bit blank, input bit en, input int line, input int col,
                      input bit wv, input int wl, input int wc, input int wd,
                      output bit acc);
      int eb;
      bit er;
      chk(rd_valid === exp_rv, rtag, int'(rd_valid), int'(exp_rv));
      chk(rd_data === DW'(exp_rd), rtag, int'(rd_data), exp_rd);
      rd_blank = blank; rd_en = en; rd_line = 3'(line); rd_col = 3'(col);
      wr_valid = wv; wr_line = 3'(wl); wr_col = 3'(wc); wr_data = DW'(wd);
      #1;
      eb = blank ? NONE : line / LPB;
      er = blank || ((wl / LPB) != (line / LPB));
      chk(rd_bank === 2'(eb), blank ? "R3" : "R2", int'(rd_bank), eb);
      chk(wr_ready === er, blank ? "R6" : (er ? "R4" : "R5"), int'(wr_ready), int'(er));
      acc = wv && er;
      if (en && !blank) begin
         exp_rv = 1'b1;
         exp_rd = model[line*NW + col];
         rtag = "R7 R9";
      end else begin
         exp_rv = 1'b0;
         rtag = blank && en ? "R8" : "R8 hold";
      end
      if (acc) model[wl*NW + wc] = wd;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      int limit = 100000;
      repeat (limit) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog act 0 exp 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit acc;
      int pl, pc, pd;
      bit pv;
      for (int i = 0; i < NL*NW; i++) model[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state, R3 none code while blank
      chk(rd_valid === 1'b0, "R1", int'(rd_valid), 0);
      chk(rd_data === '0, "R1", int'(rd_data), 0);
      chk(rd_bank === 2'(NONE), "R3", int'(rd_bank), NONE);
      rst_n = 1'b1;

      // fill the frame during blanking (R6), every bank open
      for (int l = 0; l < NL; l++)
         for (int c = 0; c < NW; c++) begin
            cyc(1, 0, 0, 0, 1, l, c, (l*37 + c*5 + 1) & 255, acc);
            chk(acc, "R6", int'(acc), 1);
         end

      // R10: idle write inputs carry junk, nothing is stored
      cyc(1, 0, 0, 0, 0, 0, 0, 8'hEE, acc);
      cyc(1, 0, 0, 0, 0, 5, 3, 8'hDD, acc);

      // R8: read during blanking is dropped
      cyc(1, 1, 2, 2, 0, 0, 0, 0, acc);
      cyc(1, 1, 6, 1, 0, 0, 0, 0, acc);

      // R5: reader on line 1 owns bank 0, write to line 2 is refused
      cyc(0, 1, 1, 0, 1, 2, 4, 8'h5A, acc);
      chk(!acc, "R5", int'(acc), 0);
      cyc(0, 0, 1, 0, 1, 2, 4, 8'h5A, acc);
      chk(!acc, "R5", int'(acc), 0);
      // reader moves to bank 1: same write now completes
      cyc(0, 1, 5, 0, 1, 2, 4, 8'h5A, acc);
      chk(acc, "R5", int'(acc), 1);
      // R4: write to the free bank while reader on bank 0
      cyc(0, 1, 0, 7, 1, 6, 6, 8'hA5, acc);
      chk(acc, "R4", int'(acc), 1);

      // full scans with a concurrent writer that retries refused writes
      pv = 1'b1; pl = 0; pc = 0; pd = 0;
      for (int frame = 0; frame < 3; frame++) begin
         for (int l = 0; l < NL; l++) begin
            for (int c = 0; c < NW + 2; c++) begin
               if (pv && pd == 0) begin
                  pl = int'($urandom_range(NL-1)); pc = int'($urandom_range(NW-1));
                  pd = int'($urandom_range(255)) | 1;
               end
               cyc(0, c < NW, l, c % NW, pv, pl, pc, pd, acc);
               if (acc) pd = 0;
               pv = ($urandom_range(3) != 0) || (pd != 0);
            end
         end
         for (int v = 0; v < 4; v++) begin
            cyc(1, 0, 0, 0, 1, v*2, v, 100 + v, acc);
            chk(acc, "R6", int'(acc), 1);
         end
      end

      // final readback of the whole frame (R9)
      for (int l = 0; l < NL; l++)
         for (int c = 0; c < NW; c++)
            cyc(0, 1, l, c, 0, 0, 0, 0, acc);
      cyc(1, 0, 0, 0, 0, 0, 0, 0, acc);
      cyc(1, 0, 0, 0, 0, 0, 0, 0, acc);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule